// File: doc/BRIEF.md
# Non-cacheable store issue controller

This block sits at the head of a store queue and hands non-cacheable stores, one at a time, to an uncached memory port. It watches the head entry of the queue. When that entry is valid and marked as an executable non-cacheable store, the block captures the entry's address, data and byte mask and presents them on a valid/ready request channel. It owns the read-data pointer and the dequeue pointer of the queue. It moves each of them on by exactly one entry when the current store is finished.

There are two completion modes, chosen per store by a mode input. In blocking mode the block waits for a response pulse after the request handshake. In outstanding mode it waits instead for a separate acceptance acknowledge from the slave, which can come several cycles late. In both modes the controller parks in a waiting state after the handshake. It cannot raise a second request for the same entry while the pointers still name that entry, so no later store is skipped.

Top module: `nc_store_issue`

## Requirements
- R1: While `rst_n` is low and after its release, `req_valid` is 0 and both pointers read zero.
- R2: When the block is idle and sees `head_valid` and `head_exec_nc` both high at a clock edge, `req_valid` is high after that edge. `req_addr`, `req_data` and `req_mask` then equal the head fields seen at that edge. If either flag is low, no request is raised.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and the request payload does not change.
- R4: In blocking mode (mode bit 0), after the request handshake `req_valid` is low and the pointers keep their value until a cycle with `resp_valid` high. That edge advances both pointers by one. `accept_ack` has no effect in this mode.
- R5: In outstanding mode (mode bit 1), after the request handshake the block waits for `accept_ack`, however many cycles it takes. `resp_valid` has no effect while it waits, and the pointers keep their value. The acknowledge edge advances both pointers by one.
- R6: `outstanding_en` is taken only when the block leaves idle. Changing it during a transaction does not change how that transaction completes.
- R7: Each pointer is {wrap bit, index}, with an index width of log2(DEPTH). One step adds one to the index. From DEPTH-1 it returns to 0 and flips the wrap bit. The two pointers are always equal.
- R8: Each entry produces exactly one request handshake. `req_valid` is low in the cycle after a handshake, and entries are issued in queue order with no entry skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| head_valid | input | 1 | Queue head entry holds a store |
| head_exec_nc | input | 1 | Head entry is an executable non-cacheable store |
| head_addr | input | ADDR_W | Head entry address |
| head_data | input | DATA_W | Head entry data |
| head_mask | input | DATA_W/8 | Head entry byte mask |
| outstanding_en | input | 1 | 1 = complete on acceptance acknowledge, 0 = complete on response |
| req_valid | output | 1 | Request to uncached port is valid |
| req_ready | input | 1 | Uncached port takes the request |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| req_mask | output | DATA_W/8 | Request byte mask |
| resp_valid | input | 1 | Completion response (blocking mode) |
| accept_ack | input | 1 | Slave acceptance acknowledge (outstanding mode) |
| rdata_ptr | output | log2(DEPTH)+1 | Read-data pointer {wrap, index} |
| deq_ptr | output | log2(DEPTH)+1 | Dequeue pointer {wrap, index} |

## Verification
A request is due one edge after the idle block sees a qualifying head entry. `req_valid` falls one edge after the handshake edge. The pointers move one edge after the completion pulse. The bench drives all inputs at the falling edge and samples outputs at the next falling edge, so every check falls exactly one edge after the stimulus it judges. During the random wait before each completion (1 to 6 cycles), the bench checks every cycle that no second request appears and that the pointers hold still. It also pulses the completion signal of the wrong mode in that window to show that the signal is ignored.

// File: rtl/nc_issue_pkg.sv
// Shared types for the non-cacheable store issue controller.
// Assumes: nothing beyond IEEE 1800-2017.
package nc_issue_pkg;

    // Controller states: idle, request on the port, waiting for a response,
    // waiting for the slave's acceptance acknowledge.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RESP = 2'd2,
        ST_ACKW = 2'd3
    } nc_state_e;

endpackage

// File: rtl/nc_issue_ptr.sv
// Queue pointer with a wrap bit: {wrap, index}.
// Steps by one entry when 'step' is high. The index returns to 0 after
// DEPTH-1 and the wrap bit flips at that point.
// Assumes: DEPTH >= 2. A power-of-two DEPTH uses a plain adder.
module nc_issue_ptr #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    output logic [IDX_W:0] ptr
);
    logic [IDX_W:0] ptr_nxt;

    generate
        if ((1 << IDX_W) == DEPTH) begin : g_pow2
            // Next value: binary add, where the carry out of the index is the wrap flip.
            always_comb ptr_nxt = ptr + 1'b1;
        end else begin : g_any
            // Next value: explicit wrap at DEPTH-1.
            always_comb begin
                if (ptr[IDX_W-1:0] == IDX_W'(DEPTH - 1))
                    ptr_nxt = {~ptr[IDX_W], {IDX_W{1'b0}}};
                else
                    ptr_nxt = {ptr[IDX_W], ptr[IDX_W-1:0] + 1'b1};
            end
        end
    endgenerate

    // Pointer register: cleared by reset, steps once per completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (step) ptr <= ptr_nxt;
    end
endmodule

// File: rtl/nc_issue_payload.sv
// Request payload holding register.
// Captures address, data and mask when 'load' is high and holds them
// until the next load, so the request stays stable while it waits for ready.
// Assumes: load is only asserted while no request is on the port.
module nc_issue_payload #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [MASK_W-1:0] in_mask,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [MASK_W-1:0] out_mask
);
    // Payload register: loads on issue start, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_data <= '0;
            out_mask <= '0;
        end else if (load) begin
            out_addr <= in_addr;
            out_data <= in_data;
            out_mask <= in_mask;
        end
    end
endmodule

// File: rtl/nc_issue_fsm.sv
// Issue sequencer for non-cacheable stores.
// idle -> request -> (response | acknowledge wait) -> idle.
// The completion mode is captured on leaving idle. 'advance' pulses for
// one cycle when the current store is finished.
// Assumes: 'start' is only meaningful in idle; the completion inputs
// are ignored in every state except the matching wait state.
module nc_issue_fsm
    import nc_issue_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      mode_in,
    input  logic      req_fire,
    input  logic      resp_valid,
    input  logic      accept_ack,
    output nc_state_e state,
    output logic      load,
    output logic      advance
);
    nc_state_e state_nxt;
    logic      mode_q;

    // Next-state logic, plus the load and advance strobes.
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        advance   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_REQ;
                    load      = 1'b1;
                end
            end
            ST_REQ: begin
                if (req_fire) state_nxt = mode_q ? ST_ACKW : ST_RESP;
            end
            ST_RESP: begin
                if (resp_valid) begin
                    state_nxt = ST_IDLE;
                    advance   = 1'b1;
                end
            end
            ST_ACKW: begin
                if (accept_ack) begin
                    state_nxt = ST_IDLE;
                    advance   = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Completion-mode register: taken only when a store is started.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= 1'b0;
        else if (load) mode_q <= mode_in;
    end
endmodule

// File: rtl/nc_store_issue.sv
// Non-cacheable store issue controller (top).
// Issues the queue-head store on an uncached request channel. It completes
// the store on a response (blocking mode) or on an acceptance acknowledge
// (outstanding mode), then steps the read-data and dequeue pointers once.
// Assumes: the queue presents the head entry selected by rdata_ptr
// combinationally on head_*; reset is synchronous and active low.
module nc_store_issue
    import nc_issue_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int MASK_W = DATA_W / 8,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int NPTR   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic              head_exec_nc,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    input  logic [MASK_W-1:0] head_mask,
    input  logic              outstanding_en,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [MASK_W-1:0] req_mask,
    input  logic              resp_valid,
    input  logic              accept_ack,
    output logic [IDX_W:0]    rdata_ptr,
    output logic [IDX_W:0]    deq_ptr
);
    nc_state_e      state;
    logic           load;
    logic           advance;
    logic           start;
    logic           req_fire;
    logic [IDX_W:0] ptr_q [NPTR];

    // Issue qualifiers: an executable non-cacheable head entry, and the handshake.
    always_comb begin
        start     = head_valid && head_exec_nc;
        req_valid = (state == ST_REQ);
        req_fire  = req_valid && req_ready;
    end

    nc_issue_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_in    (outstanding_en),
        .req_fire   (req_fire),
        .resp_valid (resp_valid),
        .accept_ack (accept_ack),
        .state      (state),
        .load       (load),
        .advance    (advance)
    );

    nc_issue_payload #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_payload (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .in_addr  (head_addr),
        .in_data  (head_data),
        .in_mask  (head_mask),
        .out_addr (req_addr),
        .out_data (req_data),
        .out_mask (req_mask)
    );

    // One pointer instance each for read-data (0) and dequeue (1).
    generate
        for (genvar g = 0; g < NPTR; g++) begin : g_ptr
            nc_issue_ptr #(.DEPTH(DEPTH)) u_ptr (
                .clk   (clk),
                .rst_n (rst_n),
                .step  (advance),
                .ptr   (ptr_q[g])
            );
        end
    endgenerate

    // Pointer outputs.
    always_comb begin
        rdata_ptr = ptr_q[0];
        deq_ptr   = ptr_q[1];
    end
endmodule

// File: rtl/nc_store_issue_chk.sv
// Assertion checker for nc_store_issue, attached by bind.
// Observes ports only. All properties are disabled while rst_n is low.
module nc_store_issue_chk #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int MASK_W = DATA_W / 8,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_data,
    input logic [MASK_W-1:0] req_mask,
    input logic              resp_valid,
    input logic              accept_ack,
    input logic [IDX_W:0]    rdata_ptr,
    input logic [IDX_W:0]    deq_ptr
);
    // Expected single step of a {wrap, index} pointer.
    function automatic logic [IDX_W:0] step_of(input logic [IDX_W:0] p);
        if (p[IDX_W-1:0] == IDX_W'(DEPTH - 1)) return {~p[IDX_W], {IDX_W{1'b0}}};
        return {p[IDX_W], p[IDX_W-1:0] + 1'b1};
    endfunction

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_data) && $stable(req_mask)));

    p_no_reissue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    p_ptr_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_ptr == deq_ptr);

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_ptr) |-> rdata_ptr == step_of($past(rdata_ptr)));

    // R4 and R5: a pointer move needs a completion pulse and no request in flight.
    p_ptr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_ptr) |-> ($past(resp_valid || accept_ack) && !$past(req_valid)));
endmodule

bind nc_store_issue nc_store_issue_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_mask   (req_mask),
    .resp_valid (resp_valid),
    .accept_ack (accept_ack),
    .rdata_ptr  (rdata_ptr),
    .deq_ptr    (deq_ptr)
);

// File: tb/nc_store_issue_tb.sv
// Self-checking bench: a table of store vectors walked in order, then
// directed tests for blocked heads, an empty queue and reset mid-request.
module nc_store_issue_tb;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int MASK_W = DATA_W / 8;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int NVEC   = 20;

    // Vector: {mode, flip_mode_mid_transaction, mask[7:0], addr[31:0]}
    localparam logic [41:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'hFF, 32'h1000_0000}, {1'b1, 1'b0, 8'h0F, 32'h1000_0008},
        {1'b1, 1'b0, 8'hF0, 32'h1000_0010}, {1'b0, 1'b1, 8'h01, 32'h2000_0004},
        {1'b1, 1'b1, 8'h80, 32'h2000_0040}, {1'b0, 1'b0, 8'h3C, 32'h3000_0100},
        {1'b1, 1'b0, 8'hFF, 32'h3000_0108}, {1'b1, 1'b0, 8'hAA, 32'h3000_0110},
        {1'b1, 1'b1, 8'h55, 32'h4000_0000}, {1'b0, 1'b0, 8'hC3, 32'h4000_0020},
        {1'b0, 1'b1, 8'h11, 32'h5000_0000}, {1'b1, 1'b0, 8'h22, 32'h5000_0008},
        {1'b0, 1'b0, 8'h44, 32'h6000_0000}, {1'b1, 1'b0, 8'h88, 32'h6000_0018},
        {1'b1, 1'b0, 8'hFF, 32'h7000_0000}, {1'b0, 1'b0, 8'h0F, 32'h7000_0ff8},
        {1'b1, 1'b0, 8'hF0, 32'h8000_0000}, {1'b0, 1'b1, 8'h03, 32'h8000_0010},
        {1'b1, 1'b0, 8'h0C, 32'h9000_0000}, {1'b0, 1'b0, 8'h30, 32'h9000_0008}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              head_valid, head_exec_nc;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic [MASK_W-1:0] head_mask;
    logic              outstanding_en;
    logic              req_valid, req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;
    logic [MASK_W-1:0] req_mask;
    logic              resp_valid, accept_ack;
    logic [IDX_W:0]    rdata_ptr, deq_ptr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    nc_store_issue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_exec_nc(head_exec_nc),
        .head_addr(head_addr), .head_data(head_data), .head_mask(head_mask),
        .outstanding_en(outstanding_en), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
        .resp_valid(resp_valid), .accept_ack(accept_ack),
        .rdata_ptr(rdata_ptr), .deq_ptr(deq_ptr)
    );

    function automatic logic [IDX_W:0] exp_ptr(input int k);
        return (IDX_W + 1)'(k % (2 * DEPTH));
    endfunction

    function automatic logic [DATA_W-1:0] data_of(input logic [ADDR_W-1:0] a);
        return {a, ~a};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_ptrs(input string req, input int k);
        check(rdata_ptr == exp_ptr(k), req, longint'(rdata_ptr), longint'(exp_ptr(k)));
        check(deq_ptr == exp_ptr(k), req, longint'(deq_ptr), longint'(exp_ptr(k)));
    endtask

    task automatic present(input int k);
        if (k < NVEC) begin
            head_valid   = 1'b1;
            head_exec_nc = 1'b1;
            head_addr    = VEC[k][31:0];
            head_data    = data_of(VEC[k][31:0]);
            head_mask    = VEC[k][39:32];
        end else begin
            head_valid   = 1'b0;
            head_exec_nc = 1'b0;
        end
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_ready = 1'b0; resp_valid = 1'b0; accept_ack = 1'b0;
        head_addr = '0; head_data = '0; head_mask = '0;
        outstanding_en = VEC[0][41];
        present(0);
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(req_valid == 1'b0, "R1 reset req_valid", longint'(req_valid), 0);
        check_ptrs("R1 reset pointers", 0);
        rst_n = 1'b1;

        // Table walk: one store per vector, in order.
        for (int i = 0; i < NVEC; i++) begin
            automatic bit mode = VEC[i][41];
            automatic bit flip = VEC[i][40];
            automatic int rdly = $urandom_range(0, 3);
            automatic int adly = $urandom_range(1, 6);
            @(negedge clk);
            // R2: the request is up one edge after the idle block sees the head.
            check(req_valid == 1'b1, "R2 request raised", longint'(req_valid), 1);
            check(req_addr == VEC[i][31:0], "R2/R8 request address in order",
                  longint'(req_addr), longint'(VEC[i][31:0]));
            check(req_data == data_of(VEC[i][31:0]), "R2 request data",
                  longint'(req_data), longint'(data_of(VEC[i][31:0])));
            check(req_mask == VEC[i][39:32], "R2 request mask",
                  longint'(req_mask), longint'(VEC[i][39:32]));
            if (flip) outstanding_en = ~mode;   // R6: no effect mid-transaction
            for (int d = 0; d < rdly; d++) begin
                @(negedge clk);
                check(req_valid && req_addr == VEC[i][31:0], "R3 request held",
                      longint'(req_addr), longint'(VEC[i][31:0]));
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            check(req_valid == 1'b0, "R8 no request after handshake", longint'(req_valid), 0);
            check_ptrs("R4/R5 pointers hold after handshake", i);
            for (int d = 0; d < adly; d++) begin
                // Pulse the other mode's completion signal once; it must be ignored.
                if (d == 0) begin
                    if (mode) resp_valid = 1'b1;
                    else      accept_ack = 1'b1;
                end
                @(negedge clk);
                resp_valid = 1'b0;
                accept_ack = 1'b0;
                check(req_valid == 1'b0, mode ? "R5 no reissue while waiting" : "R4 no reissue while waiting",
                      longint'(req_valid), 0);
                check_ptrs(mode ? "R5 pointers hold, response ignored" : "R4 pointers hold, ack ignored", i);
            end
            if (mode) accept_ack = 1'b1;
            else      resp_valid = 1'b1;
            @(negedge clk);
            resp_valid = 1'b0;
            accept_ack = 1'b0;
            check_ptrs(mode ? "R5/R6/R7 advance on acknowledge" : "R4/R6/R7 advance on response", i + 1);
            check(req_valid == 1'b0, "R8 idle after completion", longint'(req_valid), 0);
            present(i + 1);
            if (i + 1 < NVEC) outstanding_en = VEC[i+1][41];
        end

        // Empty queue: no request, pointers hold.
        repeat (4) @(negedge clk);
        check(req_valid == 1'b0, "R2 empty queue no request", longint'(req_valid), 0);
        check_ptrs("R7 pointers after wrap", NVEC);

        // Head valid but not executable: no request.
        head_valid = 1'b1; head_exec_nc = 1'b0; head_addr = 32'hDEAD_0000;
        repeat (5) @(negedge clk);
        check(req_valid == 1'b0, "R2 non-executable head ignored", longint'(req_valid), 0);
        check_ptrs("R2 pointers hold on non-executable head", NVEC);

        // Reset during a pending request.
        head_exec_nc = 1'b1;
        @(negedge clk);
        check(req_valid == 1'b1, "R2 request for late-executable head", longint'(req_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(req_valid == 1'b0, "R1 reset drops request", longint'(req_valid), 0);
        check_ptrs("R1 reset clears pointers", 0);
        @(negedge clk);
        head_valid = 1'b0; head_exec_nc = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(req_valid == 1'b0, "R1 idle after reset", longint'(req_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule